// File: doc/BRIEF.md
# Byte-mode pointer write-back stage

This stage executes one byte-wide instruction whose source operand is fetched through a working register used as a pointer. It has a bank of working registers. From the pointer register and an addressing mode it forms a byte address. It then issues one read to a 16-bit, byte-addressed, little-endian data memory and picks the addressed byte out of the returned word. The byte is either passed through or incremented by two. Two results are then committed in the same cycle: the updated pointer and the byte result.

The difficult case is when the pointer register is also the destination register. The data result always wins that clash. A parameter selects how the lost pointer update is treated. In the legacy variant the pointer update is discarded and the upper byte is cleared. In the newer variant the upper byte of the updated pointer is kept under the byte result. A word-wide load port fills registers ahead of an instruction, and a read port lets the next stage observe any register.

Top module: `bwb_stage`

## Requirements
- R1: `mode_i` selects the pointer mode: 0 plain (address = pointer, no update), 1 post-increment, 2 post-decrement, 3 pre-increment, 4 pre-decrement. The step is exactly one and wraps modulo 2^16. Pre modes address with the updated value; post modes address with the old value.
- R2: `mem_addr_o` carries the byte address with bit 0 cleared. If bit 0 of the effective address is 1, the byte is taken from bits 15:8 of `mem_rdata_i`; if it is 0, from bits 7:0.
- R3: `op_i` = 0 passes the fetched byte through. `op_i` = 1 adds two modulo 256, and no carry reaches the upper byte.
- R4: When the pointer and destination registers differ, the pointer register receives its full 16-bit updated value. The destination keeps its upper byte and takes the result in its lower byte.
- R5: With `KEEP_PTR_HI` = 0, a clash leaves 0x00 in the upper byte and the result in the lower byte. The pointer update is lost.
- R6: With `KEEP_PTR_HI` = 1, a clash leaves the upper byte of the updated pointer in the upper byte and the result in the lower byte.
- R7: An accepted `start_i` gives one cycle of `mem_re_o` in the next cycle. `done_o` is a single-cycle pulse three cycles after the start edge. Both register writes are visible on `rd_data_o` while `done_o` is high.
- R8: After reset, every register reads zero and `done_o` is low.
- R9: Registers that are neither pointer nor destination are unchanged by an instruction.
- R10: A `ld_we_i` pulse writes `ld_data_i` into register `ld_sel_i`. The new value is readable after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one instruction (ignored while busy) |
| mode_i | input | 3 | Pointer mode |
| op_i | input | 1 | 0 move, 1 add two |
| ptr_sel_i | input | 4 | Pointer register index |
| dst_sel_i | input | 4 | Destination register index |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Word-aligned byte address |
| mem_rdata_i | input | 16 | Read data, one cycle after the strobe |
| ld_we_i | input | 1 | Register load enable |
| ld_sel_i | input | 4 | Register load index |
| ld_data_i | input | 16 | Register load data |
| rd_sel_i | input | 4 | Observation read index |
| rd_data_o | output | 16 | Observation read data |
| done_o | output | 1 | Commit pulse |

## Verification
The bench builds two instances side by side, one with `KEEP_PTR_HI` = 0 and one with `KEEP_PTR_HI` = 1. Both receive the same stimulus, so every clash vector is compared against the legacy result and the newer result at once. Non-clash vectors must give identical results in both instances. The vectors cover odd and even byte lanes, and pointer steps that carry into or borrow from the upper byte. They also cover wrap of the pointer across 0x0000/0xFFFF and wrap of the add-two result past 0xFF.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN    = 3'd0,
    AM_POST_INC = 3'd1,
    AM_POST_DEC = 3'd2,
    AM_PRE_INC  = 3'd3,
    AM_PRE_DEC  = 3'd4
  } amode_e;

  typedef enum logic {
    OP_MOVE = 1'b0,
    OP_ADD2 = 1'b1
  } bop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WB   = 2'd2
  } st_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bwb_addr_gen.sv
module bwb_addr_gen
  import bwb_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  amode_e            mode_i,
  input  logic [DATA_W-1:0] ptr_i,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] nptr_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

  logic [DATA_W-1:0] inc, dec;
  assign inc = ptr_i + STEP;
  assign dec = ptr_i - STEP;

  always_comb begin
    ea_o   = ptr_i;
    nptr_o = ptr_i;
    unique case (mode_i)
      AM_POST_INC: nptr_o = inc;
      AM_POST_DEC: nptr_o = dec;
      AM_PRE_INC: begin
        ea_o   = inc;
        nptr_o = inc;
      end
      AM_PRE_DEC: begin
        ea_o   = dec;
        nptr_o = dec;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bwb_byte_alu.sv
module bwb_byte_alu
  import bwb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 1
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  bop_e              op_i,
  output logic [BYTE_W-1:0] res_o
);
  logic [BYTE_W-1:0] byte_sel;

  // little-endian: lane 0 is the low byte
  assign byte_sel = word_i[lane_i*BYTE_W +: BYTE_W];

  always_comb begin
    unique case (op_i)
      OP_ADD2: res_o = byte_sel + BYTE_W'(2);
      default: res_o = byte_sel;
    endcase
  end
endmodule

// File: rtl/bwb_merge.sv
module bwb_merge
  import bwb_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned IDX_W       = 4,
  parameter bit          KEEP_PTR_HI = 1'b0,
  localparam int unsigned HI_W       = DATA_W - BYTE_W
) (
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  ptr_idx_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [DATA_W-1:0] nptr_i,
  input  logic [HI_W-1:0]   dst_hi_i,
  input  logic [BYTE_W-1:0] res_i,
  output logic              clash_o,
  output logic              ptr_we_o,
  output logic [DATA_W-1:0] ptr_data_o,
  output logic              dat_we_o,
  output logic [DATA_W-1:0] dat_data_o
);
  logic [HI_W-1:0] clash_hi;

  assign clash_o    = (ptr_idx_i == dst_idx_i);
  // data write wins; pointer write dropped on clash
  assign ptr_we_o   = commit_i && !clash_o;
  assign ptr_data_o = nptr_i;
  assign dat_we_o   = commit_i;
  assign clash_hi   = nptr_i[DATA_W-1:BYTE_W] & {HI_W{KEEP_PTR_HI}};
  assign dat_data_o = clash_o ? {clash_hi, res_i} : {dst_hi_i, res_i};
endmodule

// File: rtl/bwb_regfile.sv
module bwb_regfile
  import bwb_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned IDX_W    = 4,
  localparam int unsigned HI_W    = DATA_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_we_i,
  input  logic [IDX_W-1:0]  ptr_idx_i,
  input  logic [DATA_W-1:0] ptr_data_i,
  input  logic              dat_we_i,
  input  logic [IDX_W-1:0]  dat_idx_i,
  input  logic [DATA_W-1:0] dat_data_i,
  input  logic              ld_we_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [HI_W-1:0]   rb_hi_o,
  input  logic [IDX_W-1:0]  rc_idx_i,
  output logic [DATA_W-1:0] rc_data_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      regs_q[g] <= '0;
      else if (dat_we_i && dat_idx_i == IDX_W'(g))      regs_q[g] <= dat_data_i;
      else if (ptr_we_i && ptr_idx_i == IDX_W'(g))      regs_q[g] <= ptr_data_i;
      else if (ld_we_i && ld_idx_i == IDX_W'(g))        regs_q[g] <= ld_data_i;
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_hi_o   = regs_q[rb_idx_i][DATA_W-1:BYTE_W];
  assign rc_data_o = regs_q[rc_idx_i];

  // R4: pointer write lands in full unless the data port hits the same register
  a_r4_ptr_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_i && !(dat_we_i && dat_idx_i == ptr_idx_i))
      |=> (regs_q[$past(ptr_idx_i)] == $past(ptr_data_i)));

  // R9/R5: data write always lands
  a_r9_dat_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i |=> (regs_q[$past(dat_idx_i)] == $past(dat_data_i)));
endmodule

// File: rtl/bwb_stage.sv
module bwb_stage
  import bwb_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_REGS    = 16,
  parameter bit          KEEP_PTR_HI = 1'b0,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS),
  localparam int unsigned HI_W       = DATA_W - BYTE_W,
  localparam int unsigned LANES      = DATA_W / BYTE_W,
  localparam int unsigned LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic              op_i,
  input  logic [IDX_W-1:0]  ptr_sel_i,
  input  logic [IDX_W-1:0]  dst_sel_i,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              ld_we_i,
  input  logic [IDX_W-1:0]  ld_sel_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [IDX_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);
  st_e               state_q;
  logic              accept, commit, clash;
  logic [DATA_W-1:0] ptr_val, ea, nptr;
  logic [DATA_W-1:0] ea_q, nptr_q;
  logic [IDX_W-1:0]  ptr_q, dst_q;
  bop_e              op_q;
  logic              done_q;
  logic [HI_W-1:0]   dst_hi;
  logic [BYTE_W-1:0] res;
  logic              ptr_we, dat_we;
  logic [DATA_W-1:0] ptr_wd, dat_wd;

  assign accept = start_i && (state_q == ST_IDLE);
  assign commit = (state_q == ST_WB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      nptr_q  <= '0;
      ptr_q   <= '0;
      dst_q   <= '0;
      op_q    <= OP_MOVE;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RD;
          ea_q    <= ea;
          nptr_q  <= nptr;
          ptr_q   <= ptr_sel_i;
          dst_q   <= dst_sel_i;
          op_q    <= bop_e'(op_i);
        end
        ST_RD:   state_q <= ST_WB;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  bwb_addr_gen #(.DATA_W(DATA_W)) u_addr (
    .mode_i (amode_e'(mode_i)),
    .ptr_i  (ptr_val),
    .ea_o   (ea),
    .nptr_o (nptr)
  );

  assign mem_re_o   = (state_q == ST_RD);
  assign mem_addr_o = {ea_q[DATA_W-1:LANE_W], {LANE_W{1'b0}}};

  bwb_byte_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_alu (
    .word_i (mem_rdata_i),
    .lane_i (ea_q[LANE_W-1:0]),
    .op_i   (op_q),
    .res_o  (res)
  );

  bwb_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W), .KEEP_PTR_HI(KEEP_PTR_HI)) u_merge (
    .commit_i   (commit),
    .ptr_idx_i  (ptr_q),
    .dst_idx_i  (dst_q),
    .nptr_i     (nptr_q),
    .dst_hi_i   (dst_hi),
    .res_i      (res),
    .clash_o    (clash),
    .ptr_we_o   (ptr_we),
    .ptr_data_o (ptr_wd),
    .dat_we_o   (dat_we),
    .dat_data_o (dat_wd)
  );

  bwb_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_we_i   (ptr_we),
    .ptr_idx_i  (ptr_q),
    .ptr_data_i (ptr_wd),
    .dat_we_i   (dat_we),
    .dat_idx_i  (dst_q),
    .dat_data_i (dat_wd),
    .ld_we_i    (ld_we_i),
    .ld_idx_i   (ld_sel_i),
    .ld_data_i  (ld_data_i),
    .ra_idx_i   (ptr_sel_i),
    .ra_data_o  (ptr_val),
    .rb_idx_i   (dst_q),
    .rb_hi_o    (dst_hi),
    .rc_idx_i   (rd_sel_i),
    .rc_data_o  (rd_data_o)
  );

  assign done_o = done_q;

  // R1: pointer moves by at most one per instruction
  a_r1_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((nptr_q == $past(ptr_val)) ||
                (nptr_q == $past(ptr_val) + DATA_W'(1)) ||
                (nptr_q == $past(ptr_val) - DATA_W'(1))));

  // R7: read strobe is one cycle, then commit, then done
  a_r7_re_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (!mem_re_o && commit));
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_commit_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> done_o);

  // R5/R6: upper byte after a clash follows the policy
  a_r6_clash_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && clash) |=>
      (dst_hi == (KEEP_PTR_HI ? nptr_q[DATA_W-1:BYTE_W] : HI_W'(0))));

  // R4: destination upper byte survives a non-clash write
  a_r4_dst_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !clash && !ld_we_i) |=> (dst_hi == $past(dst_hi)));
endmodule

// File: tb/bwb_stage_tb.sv
module bwb_stage_tb;
  typedef struct packed {
    logic [3:0]  p;
    logic [3:0]  d;
    logic [2:0]  m;
    logic        o;
    logic [15:0] pi;
    logic [15:0] di;
    logic [15:0] ep;
    logic [15:0] el;
    logic [15:0] ek;
  } vec_t;

  localparam int NV = 12;
  // p, d, mode, op, ptr init, dst init, exp ptr, exp dst legacy, exp dst keep
  localparam vec_t VECS [NV] = '{
    '{4'd0,  4'd0,  3'd1, 1'b0, 16'h12FF, 16'h0000, 16'h1300, 16'h00AA, 16'h13AA}, // R2 odd lane, R6 carry
    '{4'd12, 4'd12, 3'd1, 1'b1, 16'h74FF, 16'h0000, 16'h7500, 16'h00F5, 16'h75F5}, // R3 add two
    '{4'd0,  4'd0,  3'd3, 1'b0, 16'h1234, 16'h0000, 16'h1235, 16'h00AA, 16'h12AA}, // R1 pre-inc
    '{4'd0,  4'd0,  3'd4, 1'b0, 16'h1300, 16'h0000, 16'h12FF, 16'h00AA, 16'h12AA}, // R1 pre-dec borrow
    '{4'd0,  4'd0,  3'd1, 1'b0, 16'h1234, 16'h0000, 16'h1235, 16'h0055, 16'h1255}, // R2 even lane
    '{4'd1,  4'd2,  3'd2, 1'b0, 16'h12FE, 16'hBEEF, 16'h12FD, 16'hBE55, 16'hBE55}, // R4 post-dec
    '{4'd3,  4'd4,  3'd0, 1'b1, 16'h2000, 16'h1234, 16'h2000, 16'h1201, 16'h1201}, // R3 wrap, R1 plain
    '{4'd5,  4'd5,  3'd0, 1'b1, 16'h2000, 16'h0000, 16'h2000, 16'h0001, 16'h2001}, // R5 plain clash
    '{4'd6,  4'd7,  3'd3, 1'b0, 16'h12FE, 16'h0000, 16'h12FF, 16'h00AA, 16'h00AA}, // R4 pre-inc
    '{4'd8,  4'd9,  3'd4, 1'b1, 16'h1235, 16'hFFFF, 16'h1234, 16'hFF57, 16'hFF57}, // R4 dst hi kept
    '{4'd10, 4'd10, 3'd2, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 16'h0081, 16'hFF81}, // R1 wrap down
    '{4'd11, 4'd11, 3'd1, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0042, 16'h0042}  // R1 wrap up
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        op_i = 1'b0;
  logic [3:0]  ptr_sel_i = '0, dst_sel_i = '0;
  logic        ld_we_i = 1'b0;
  logic [3:0]  ld_sel_i = '0, rd_sel_i = '0;
  logic [15:0] ld_data_i = '0;
  logic        re_a, re_b, done_a, done_b;
  logic [15:0] addr_a, addr_b, rdat_a, rdat_b, rd_a, rd_b;
  int          n_checks = 0;
  int          n_errs = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    case (a & 16'hFFFE)
      16'h12FE, 16'h1234: return 16'hAA55;
      16'h74FE:           return 16'hF321;
      16'h2000:           return 16'h00FF;
      16'h0000:           return 16'h7E81;
      16'hFFFE:           return 16'h42C3;
      default:            return 16'hDEAD;
    endcase
  endfunction

  always_ff @(posedge clk_i) begin
    if (re_a) rdat_a <= mem_word(addr_a);
    if (re_b) rdat_b <= mem_word(addr_b);
  end

  bwb_stage #(.KEEP_PTR_HI(1'b0)) u_dut (
    .clk_i, .rst_ni, .start_i, .mode_i, .op_i, .ptr_sel_i, .dst_sel_i,
    .mem_re_o(re_a), .mem_addr_o(addr_a), .mem_rdata_i(rdat_a),
    .ld_we_i, .ld_sel_i, .ld_data_i, .rd_sel_i, .rd_data_o(rd_a), .done_o(done_a)
  );

  bwb_stage #(.KEEP_PTR_HI(1'b1)) u_dut_keep (
    .clk_i, .rst_ni, .start_i, .mode_i, .op_i, .ptr_sel_i, .dst_sel_i,
    .mem_re_o(re_b), .mem_addr_o(addr_b), .mem_rdata_i(rdat_b),
    .ld_we_i, .ld_sel_i, .ld_data_i, .rd_sel_i, .rd_data_o(rd_b), .done_o(done_b)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] idx, input logic [15:0] val);
    ld_we_i = 1'b1; ld_sel_i = idx; ld_data_i = val;
    @(negedge clk_i);
    ld_we_i = 1'b0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [15:0] a, output logic [15:0] b);
    rd_sel_i = idx;
    #1;
    a = rd_a; b = rd_b;
  endtask

  initial begin
    #(20 * 200000);
    n_errs++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [15:0] va, vb, ea;
    int          lat, res;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    check("R8 done_o", {15'h0, done_a | done_b}, 16'h0);
    for (int i = 0; i < 16; i++) begin
      peek(i[3:0], va, vb);
      check("R8 reg zero", va | vb, 16'h0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 load port
    load(4'd15, 16'h5A5A);
    peek(4'd15, va, vb);
    check("R10 load a", va, 16'h5A5A);
    check("R10 load b", vb, 16'h5A5A);

    for (int v = 0; v < NV; v++) begin
      load(VECS[v].p, VECS[v].pi);
      if (VECS[v].p != VECS[v].d) load(VECS[v].d, VECS[v].di);
      start_i = 1'b1; mode_i = VECS[v].m; op_i = VECS[v].o;
      ptr_sel_i = VECS[v].p; dst_sel_i = VECS[v].d;
      @(negedge clk_i);
      start_i = 1'b0;
      // R1/R2: aligned byte address in the read cycle
      case (VECS[v].m)
        3'd3:    ea = VECS[v].pi + 16'd1;
        3'd4:    ea = VECS[v].pi - 16'd1;
        default: ea = VECS[v].pi;
      endcase
      check("R7 mem_re_o", {15'h0, re_a & re_b}, 16'h1);
      check("R2 mem_addr_o", addr_a, ea & 16'hFFFE);
      lat = 1; res = 1;
      while (!done_a) begin
        @(negedge clk_i);
        lat++;
        if (re_a) res++;
        if (lat > 20) break;
      end
      check("R7 latency", 16'(lat), 16'd3);
      check("R7 single read", 16'(res), 16'd1);
      check("R7 done both", {15'h0, done_b}, 16'h1);
      if (VECS[v].p == VECS[v].d) begin
        peek(VECS[v].d, va, vb);
        check("R5 clash legacy", va, VECS[v].el);
        check("R6 clash keep", vb, VECS[v].ek);
      end else begin
        peek(VECS[v].p, va, vb);
        check("R4 ptr legacy", va, VECS[v].ep);
        check("R4 ptr keep", vb, VECS[v].ep);
        peek(VECS[v].d, va, vb);
        check("R3 R4 dst legacy", va, VECS[v].el);
        check("R3 R4 dst keep", vb, VECS[v].ek);
      end
      peek(4'd15, va, vb);
      check("R9 bystander", va ^ vb ^ va, 16'h5A5A);
      check("R9 bystander keep", vb, 16'h5A5A);
      @(negedge clk_i);
      check("R7 done pulse", {15'h0, done_a | done_b}, 16'h0);
    end
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule